// File: doc/BRIEF.md
# Serial Port-Expander Control Core

This core is the control logic of a 24-line I/O expander. A host reaches it through a four-wire serial link: a chip select (active low), a serial clock, a data input and a data output. Every transaction begins with an opcode byte. A write command is followed by one data byte. A read command is followed by one byte that the host clocks in while the core shifts the answer out. The core holds the configuration registers for three 8-bit ports. Port 0 is input only, port 1 is bidirectional and port 2 is output only. It drives the pad control bits from those registers. It does not model the pads.

The device must be unlocked before it responds. The host writes a chip address, and the core compares the low three bits against strap pins. Until they match, the core obeys only the address command and a two-byte software reset. A pin on port 0 or port 1 whose enable bit is set records an event when its synchronized level changes. An active-low interrupt output goes low while any enabled event is pending. A single command clears all events on both ports.

The serial signals are synchronized into the core clock domain. The serial clock must therefore stay at least four core cycles in each phase.

Top module: `pexp_ctrl`

## Requirements
- R1: Serial bits are captured most significant bit first on rising serial-clock edges while `cs_n` is low. Raising `cs_n` discards a partly received byte, and the next byte is decoded as an opcode.
- R2: The data byte of opcode 0xFD unlocks the device when its bits [2:0] equal `strap_addr`. Any other value locks the device.
- R3: While the device is locked, every opcode other than 0xFD and 0xFE is ignored.
- R4: Write opcodes load their data byte into these registers:
  - Port 0: pull-up 0x04, strong pull 0x0A, interrupt enable 0x10.
  - Port 1: data 0x0E, direction 0x02, pull/output mode 0x05, strong pull 0x0B, sink 0x08, interrupt enable 0x11.
  - Port 2: data 0x0F, mode 0x06, sink 0x09, pull-up 0x0C.
- R5: Read opcodes return these values:
  - Port 0: pull-up 0x34, strong pull 0x3A.
  - Port 1: direction 0x32, pull/output mode 0x35, strong pull 0x3B, sink 0x38.
  - Port 2: mode 0x36, sink 0x39, pull-up 0x3C.
  - Synchronized pin levels: port 0 0x3D, port 1 0x3E.
  - Event status: port 0 0x43, port 1 0x44.
- R6: Read data appears on `sdo` most significant bit first. It changes only after falling serial-clock edges, or when it is loaded at the end of the opcode byte. Each bit is valid at the rising edge where the host samples it.
- R7: Bytes 0xFE then 0xFF in one frame clear every register and lock the device. A byte other than 0xFF after 0xFE does nothing.
- R8: An event bit is set when its synchronized pin changes while the matching enable bit is 1. A change on a pin whose enable bit is 0 sets nothing.
- R9: `irq_n` is low exactly while some event bit and its enable bit are both 1.
- R10: Opcode 0x13 clears the event bits of port 0 and port 1 together.
- R11: An opcode outside the listed set changes no register.
- R12: After reset, all control outputs are 0, `sdo` is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| sclk | input | 1 | serial clock from host |
| cs_n | input | 1 | frame select, active low |
| sdi | input | 1 | serial data from host |
| strap_addr | input | 3 | address strap pins |
| p0_pins | input | 8 | port 0 pad levels |
| p1_pins | input | 8 | port 1 pad levels |
| sdo | output | 1 | serial read data |
| irq_n | output | 1 | interrupt, active low |
| p0_pullup | output | 8 | port 0 pull-up enables |
| p0_strong | output | 8 | port 0 strong-pull selects |
| p1_data | output | 8 | port 1 output data |
| p1_dir | output | 8 | port 1 direction |
| p1_pullmode | output | 8 | port 1 pull/output mode |
| p1_strong | output | 8 | port 1 strong-pull selects |
| p1_sink | output | 8 | port 1 sink controls |
| p2_data | output | 8 | port 2 output data |
| p2_mode | output | 8 | port 2 output mode |
| p2_sink | output | 8 | port 2 sink controls |
| p2_pullup | output | 8 | port 2 pull-up enables |

## Verification
The assertions take for granted that the serial clock and `cs_n` change slowly enough to be seen as clean single edges after synchronization. This means a rising and a falling serial edge never land in the same core cycle. They also assume a byte-complete pulse can only follow a detected rising edge.

The stimulus keeps each serial phase at eight core cycles. It holds data steady a full half period before each rising edge and moves `cs_n` only while the serial clock is low. It also changes pad levels only between frames, so each event check sees a single synchronized transition.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {DS_OPC, DS_WDAT, DS_RDAT, DS_RST2} dec_st_e;

  typedef enum logic [3:0] {
    RI_P0PU, RI_P0SPU, RI_P0IEN,
    RI_P1DAT, RI_P1DIR, RI_P1POM, RI_P1SPU, RI_P1SNK, RI_P1IEN,
    RI_P2DAT, RI_P2MODE, RI_P2SNK, RI_P2PU
  } reg_idx_e;

  localparam int NREG = 13;

  localparam logic [7:0] OP_RST_A = 8'hFE;
  localparam logic [7:0] OP_RST_B = 8'hFF;
  localparam logic [7:0] OP_EVCLR = 8'h13;
  localparam logic [7:0] OP_ADDR  = 8'hFD;

  typedef struct packed {
    logic     ok;
    reg_idx_e idx;
  } wr_dec_t;

  // Map a write opcode to the register it loads.
  function automatic wr_dec_t wr_lookup(input logic [7:0] op);
    wr_dec_t r;
    r.ok  = 1'b1;
    r.idx = RI_P0PU;
    case (op)
      8'h04: r.idx = RI_P0PU;
      8'h0A: r.idx = RI_P0SPU;
      8'h10: r.idx = RI_P0IEN;
      8'h0E: r.idx = RI_P1DAT;
      8'h02: r.idx = RI_P1DIR;
      8'h05: r.idx = RI_P1POM;
      8'h0B: r.idx = RI_P1SPU;
      8'h08: r.idx = RI_P1SNK;
      8'h11: r.idx = RI_P1IEN;
      8'h0F: r.idx = RI_P2DAT;
      8'h06: r.idx = RI_P2MODE;
      8'h09: r.idx = RI_P2SNK;
      8'h0C: r.idx = RI_P2PU;
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pexp_serial.sv
module pexp_serial #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_byte,
  output logic          rx_valid,
  output logic [DW-1:0] rx_byte,
  output logic          frame_idle,
  output logic          sclk_rise,
  output logic          sclk_fall,
  output logic          sdo
);
  localparam int CW = $clog2(DW);

  logic [SYNC-1:0] sclk_sq, csn_sq, sdi_sq;
  logic            sclk_d_q;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [DW-1:0]   sh_q, sh_d, tx_q, tx_d;
  logic            vld_q, vld_d;

  assign frame_idle = csn_sq[SYNC-1];
  assign sclk_rise  = sclk_sq[SYNC-1] & ~sclk_d_q;
  assign sclk_fall  = ~sclk_sq[SYNC-1] & sclk_d_q;
  assign rx_valid   = vld_q;
  assign rx_byte    = sh_q;
  assign sdo        = tx_q[DW-1];

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    tx_d  = tx_q;
    vld_d = 1'b0;
    if (frame_idle) begin
      cnt_d = '0;
      tx_d  = '0;
    end else begin
      if (sclk_rise) begin
        sh_d = {sh_q[DW-2:0], sdi_sq[SYNC-1]};
        if (cnt_q == CW'(DW-1)) begin
          cnt_d = '0;
          vld_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      // hold the first bit across the fall that ends the previous byte
      if (sclk_fall && cnt_q != '0) tx_d = {tx_q[DW-2:0], 1'b0};
      if (tx_load) tx_d = tx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sq  <= '0;
      csn_sq   <= '1;
      sdi_sq   <= '0;
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      vld_q    <= 1'b0;
    end else begin
      sclk_sq  <= {sclk_sq[SYNC-2:0], sclk};
      csn_sq   <= {csn_sq[SYNC-2:0], cs_n};
      sdi_sq   <= {sdi_sq[SYNC-2:0], sdi};
      sclk_d_q <= sclk_sq[SYNC-1];
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      tx_q     <= tx_d;
      vld_q    <= vld_d;
    end
  end
endmodule

// File: rtl/pexp_regs.sv
module pexp_regs
  import pexp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_valid,
  input  logic [DW-1:0]            rx_byte,
  input  logic                     frame_idle,
  input  logic [AW-1:0]            strap_addr,
  input  logic [1:0][DW-1:0]       pins_s,
  input  logic [1:0][DW-1:0]       evt,
  output logic [NREG-1:0][DW-1:0]  cfg_q,
  output logic                     dev_en,
  output logic                     wr_hit,
  output logic                     tx_load,
  output logic [DW-1:0]            tx_byte,
  output logic                     evt_clr,
  output logic                     sreset
);
  dec_st_e                   st_q, st_d;
  logic                      en_q, en_d;
  logic [DW-1:0]             op_q, op_d;
  logic [NREG-1:0][DW-1:0]   cfg_d;
  logic                      rd_ok;
  logic [DW-1:0]             rd_val;
  wr_dec_t                   wnew, wcur;

  assign dev_en = en_q;
  assign wnew   = wr_lookup(rx_byte);
  assign wcur   = wr_lookup(op_q);

  // read source selection
  always_comb begin
    rd_ok  = 1'b1;
    rd_val = '0;
    case (rx_byte)
      8'h34: rd_val = cfg_q[RI_P0PU];
      8'h3A: rd_val = cfg_q[RI_P0SPU];
      8'h3D: rd_val = pins_s[0];
      8'h43: rd_val = evt[0];
      8'h32: rd_val = cfg_q[RI_P1DIR];
      8'h35: rd_val = cfg_q[RI_P1POM];
      8'h3B: rd_val = cfg_q[RI_P1SPU];
      8'h38: rd_val = cfg_q[RI_P1SNK];
      8'h3E: rd_val = pins_s[1];
      8'h44: rd_val = evt[1];
      8'h36: rd_val = cfg_q[RI_P2MODE];
      8'h39: rd_val = cfg_q[RI_P2SNK];
      8'h3C: rd_val = cfg_q[RI_P2PU];
      default: rd_ok = 1'b0;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    en_d    = en_q;
    op_d    = op_q;
    cfg_d   = cfg_q;
    tx_load = 1'b0;
    tx_byte = '0;
    evt_clr = 1'b0;
    sreset  = 1'b0;
    wr_hit  = 1'b0;
    if (frame_idle) begin
      st_d = DS_OPC;
    end else if (rx_valid) begin
      case (st_q)
        DS_OPC: begin
          op_d = rx_byte;
          if (rx_byte == OP_RST_A)      st_d = DS_RST2;
          else if (rx_byte == OP_ADDR)  st_d = DS_WDAT;
          else if (en_q) begin
            if (rx_byte == OP_EVCLR)    evt_clr = 1'b1;
            else if (wnew.ok)           st_d = DS_WDAT;
            else if (rd_ok) begin
              tx_load = 1'b1;
              tx_byte = rd_val;
              st_d    = DS_RDAT;
            end
          end
        end
        DS_WDAT: begin
          st_d = DS_OPC;
          if (op_q == OP_ADDR) begin
            en_d = (rx_byte[AW-1:0] == strap_addr);
          end else if (wcur.ok) begin
            wr_hit           = 1'b1;
            cfg_d[wcur.idx]  = rx_byte;
          end
        end
        DS_RDAT: st_d = DS_OPC;
        default: begin
          st_d = DS_OPC;
          if (rx_byte == OP_RST_B) sreset = 1'b1;
        end
      endcase
    end
    if (sreset) begin
      cfg_d = '0;
      en_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DS_OPC;
      en_q  <= 1'b0;
      op_q  <= '0;
      cfg_q <= '0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_d;
      op_q  <= op_d;
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/pexp_events.sv
module pexp_events #(
  parameter int DW    = 8,
  parameter int NPORT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0][DW-1:0] pins,
  input  logic [NPORT-1:0][DW-1:0] ien,
  input  logic                  clr,
  output logic [NPORT-1:0][DW-1:0] pins_s,
  output logic [NPORT-1:0][DW-1:0] evt,
  output logic                  irq_n
);
  logic [NPORT-1:0][DW-1:0] s1_q, s2_q, s3_q, evt_q, evt_d;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_comb begin
      if (clr) evt_d[p] = '0;
      else     evt_d[p] = evt_q[p] | (ien[p] & (s2_q[p] ^ s3_q[p]));
    end
  end

  assign pins_s = s2_q;
  assign evt    = evt_q;
  assign irq_n  = ~|(evt_q & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      s3_q  <= '0;
      evt_q <= '0;
    end else begin
      s1_q  <= pins;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      evt_q <= evt_d;
    end
  end
endmodule

// File: rtl/pexp_ctrl.sv
module pexp_ctrl
  import pexp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  input  logic [AW-1:0] strap_addr,
  input  logic [DW-1:0] p0_pins,
  input  logic [DW-1:0] p1_pins,
  output logic          sdo,
  output logic          irq_n,
  output logic [DW-1:0] p0_pullup,
  output logic [DW-1:0] p0_strong,
  output logic [DW-1:0] p1_data,
  output logic [DW-1:0] p1_dir,
  output logic [DW-1:0] p1_pullmode,
  output logic [DW-1:0] p1_strong,
  output logic [DW-1:0] p1_sink,
  output logic [DW-1:0] p2_data,
  output logic [DW-1:0] p2_mode,
  output logic [DW-1:0] p2_sink,
  output logic [DW-1:0] p2_pullup
);
  logic [1:0]                rst_sq;
  logic                      rst_n_s;
  logic                      rx_valid, frame_idle, sclk_rise, sclk_fall;
  logic [DW-1:0]             rx_byte, tx_byte;
  logic                      tx_load, evt_clr, sreset, dev_en, wr_hit;
  logic [NREG-1:0][DW-1:0]   cfg_q;
  logic [1:0][DW-1:0]        pins_v, pins_s, ien_v, evt_v;

  // reset asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_n_s = rst_sq[1];

  pexp_serial #(.DW(DW)) u_ser (
    .clk(clk), .rst_n(rst_n_s), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .tx_load(tx_load), .tx_byte(tx_byte), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .frame_idle(frame_idle), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .sdo(sdo)
  );

  pexp_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .frame_idle(frame_idle), .strap_addr(strap_addr), .pins_s(pins_s),
    .evt(evt_v), .cfg_q(cfg_q), .dev_en(dev_en), .wr_hit(wr_hit),
    .tx_load(tx_load), .tx_byte(tx_byte), .evt_clr(evt_clr), .sreset(sreset)
  );

  assign pins_v[0] = p0_pins;
  assign pins_v[1] = p1_pins;
  assign ien_v[0]  = cfg_q[RI_P0IEN];
  assign ien_v[1]  = cfg_q[RI_P1IEN];

  pexp_events #(.DW(DW), .NPORT(2)) u_evt (
    .clk(clk), .rst_n(rst_n_s), .pins(pins_v), .ien(ien_v),
    .clr(evt_clr | sreset), .pins_s(pins_s), .evt(evt_v), .irq_n(irq_n)
  );

  assign p0_pullup   = cfg_q[RI_P0PU];
  assign p0_strong   = cfg_q[RI_P0SPU];
  assign p1_data     = cfg_q[RI_P1DAT];
  assign p1_dir      = cfg_q[RI_P1DIR];
  assign p1_pullmode = cfg_q[RI_P1POM];
  assign p1_strong   = cfg_q[RI_P1SPU];
  assign p1_sink     = cfg_q[RI_P1SNK];
  assign p2_data     = cfg_q[RI_P2DAT];
  assign p2_mode     = cfg_q[RI_P2MODE];
  assign p2_sink     = cfg_q[RI_P2SNK];
  assign p2_pullup   = cfg_q[RI_P2PU];
endmodule

// File: rtl/pexp_ctrl_chk.sv
module pexp_ctrl_chk #(
  parameter int DW = 8,
  parameter int NR = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_idle,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input logic             rx_valid,
  input logic             tx_load,
  input logic             sdo,
  input logic             dev_en,
  input logic             wr_hit,
  input logic             evt_clr,
  input logic             sreset,
  input logic [NR*DW-1:0] cfg,
  input logic [2*DW-1:0]  evt,
  input logic [2*DW-1:0]  ien
);
  assert_idle_no_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idle |=> !rx_valid);

  assert_byte_after_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sclk_rise));

  assert_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_en |-> (!wr_hit && !tx_load && !evt_clr));

  assert_sdo_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !tx_load && !frame_idle) |=> $stable(sdo));

  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (cfg == '0 && !dev_en));

  assert_evt_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~$past(evt) & ~$past(ien)) == '0));

  assert_evt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clr |=> (evt == '0));
endmodule

bind pexp_ctrl pexp_ctrl_chk #(.DW(DW), .NR(pexp_pkg::NREG)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .frame_idle(frame_idle), .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall), .rx_valid(rx_valid), .tx_load(tx_load), .sdo(sdo),
  .dev_en(dev_en), .wr_hit(wr_hit), .evt_clr(evt_clr), .sreset(sreset),
  .cfg(cfg_q), .evt(evt_v), .ien(ien_v)
);

// File: tb/pexp_ctrl_bench.sv
module pexp_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8 * CLK_PERIOD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [2:0] strap_addr = 3'b101;
  logic [7:0] p0_pins = 8'h00, p1_pins = 8'h00;
  logic       sdo, irq_n;
  logic [7:0] p0_pullup, p0_strong, p1_data, p1_dir, p1_pullmode, p1_strong,
              p1_sink, p2_data, p2_mode, p2_sink, p2_pullup;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rd_got;
  event       rd_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  pexp_ctrl u_pexp_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .strap_addr(strap_addr), .p0_pins(p0_pins), .p1_pins(p1_pins),
    .sdo(sdo), .irq_n(irq_n), .p0_pullup(p0_pullup), .p0_strong(p0_strong),
    .p1_data(p1_data), .p1_dir(p1_dir), .p1_pullmode(p1_pullmode),
    .p1_strong(p1_strong), .p1_sink(p1_sink), .p2_data(p2_data),
    .p2_mode(p2_mode), .p2_sink(p2_sink), .p2_pullup(p2_pullup)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      #(HALF);
      got[i] = sdo;
      sclk = 1'b1;
      #(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic fstart;
    cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic fend;
    #(HALF);
    cs_n = 1'b1;
    #(4*HALF);
  endtask

  task automatic wr(input logic [7:0] op, input logic [7:0] d);
    logic [7:0] g;
    fstart(); xfer(op, g); xfer(d, g); fend();
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] g;
    fstart(); xfer(op, g); fend();
  endtask

  // driver side of the scoreboard
  task automatic rd(input logic [7:0] op, input logic [7:0] exp, input string tag);
    logic [7:0] g;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    fstart(); xfer(op, g); xfer(8'h00, g); fend();
    rd_got = g;
    ->rd_ev;
    #1;
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read actual %0h expected none", rd_got);
      end else begin
        chk(tag_q.pop_front(), {24'h0, rd_got}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] g;
    #(5*CLK_PERIOD);
    rst_n = 1'b1;
    #(10*CLK_PERIOD);
    // R12 reset state
    chk("R12 sdo", {31'h0, sdo}, 32'h0);
    chk("R12 irq_n", {31'h0, irq_n}, 32'h1);
    chk("R12 outputs", {p0_pullup, p1_dir, p2_data, p2_pullup}, 32'h0);

    // R3 locked: write ignored
    wr(8'h0F, 8'h5A);
    chk("R3 locked write", {24'h0, p2_data}, 32'h0);
    // R2 wrong address keeps lock
    wr(8'hFD, 8'h03);
    wr(8'h0F, 8'h5A);
    chk("R2 mismatch", {24'h0, p2_data}, 32'h0);
    // R2 match on low three bits only
    wr(8'hFD, 8'h0D);
    wr(8'h0F, 8'h5A);
    chk("R2 match", {24'h0, p2_data}, 32'h5A);

    // R4 writes
    wr(8'h04, 8'h11); wr(8'h0A, 8'h22); wr(8'h0E, 8'h33); wr(8'h02, 8'h44);
    wr(8'h05, 8'h55); wr(8'h0B, 8'h66); wr(8'h08, 8'h77); wr(8'h06, 8'h88);
    wr(8'h09, 8'h99); wr(8'h0C, 8'hAA);
    chk("R4 p0", {p0_pullup, p0_strong}, 32'h1122);
    chk("R4 p1", {p1_data, p1_dir, p1_pullmode, p1_strong}, 32'h33445566);
    chk("R4 p1 sink", {24'h0, p1_sink}, 32'h77);
    chk("R4 p2", {p2_mode, p2_sink, p2_pullup}, 32'h8899AA);

    // R5 / R6 reads
    rd(8'h34, 8'h11, "R5 p0 pullup");
    rd(8'h3A, 8'h22, "R5 p0 strong");
    rd(8'h32, 8'h44, "R6 p1 dir");
    rd(8'h35, 8'h55, "R5 p1 mode");
    rd(8'h3B, 8'h66, "R5 p1 strong");
    rd(8'h38, 8'h77, "R5 p1 sink");
    rd(8'h36, 8'h88, "R5 p2 mode");
    rd(8'h39, 8'h99, "R5 p2 sink");
    rd(8'h3C, 8'hAA, "R6 p2 pullup");
    p0_pins = 8'hC3; p1_pins = 8'h3C;
    #(20*CLK_PERIOD);
    rd(8'h3D, 8'hC3, "R5 p0 pins");
    rd(8'h3E, 8'h3C, "R5 p1 pins");

    // R1 partial byte discarded by deselect
    fstart();
    for (int i = 0; i < 4; i++) begin
      sdi = 1'b1; #(HALF); sclk = 1'b1; #(HALF); sclk = 1'b0;
    end
    fend();
    wr(8'h0F, 8'h3C);
    chk("R1 after partial", {24'h0, p2_data}, 32'h3C);

    // R8 / R9 events
    wr(8'h10, 8'h01);
    p0_pins = 8'hC2;
    #(20*CLK_PERIOD);
    chk("R9 irq low", {31'h0, irq_n}, 32'h0);
    p0_pins = 8'hC0;
    #(20*CLK_PERIOD);
    rd(8'h43, 8'h01, "R8 enabled only");
    wr(8'h11, 8'h80);
    p1_pins = 8'hBC;
    #(20*CLK_PERIOD);
    rd(8'h44, 8'h80, "R8 port1");

    // R10 clear
    cmd1(8'h13);
    chk("R10 irq released", {31'h0, irq_n}, 32'h1);
    rd(8'h43, 8'h00, "R10 p0 cleared");
    rd(8'h44, 8'h00, "R10 p1 cleared");

    // R11 undefined opcode
    fstart(); xfer(8'h20, g); xfer(8'h55, g); fend();
    chk("R11 undefined", {p2_data, p1_data, p0_pullup}, {8'h0, 8'h3C, 8'h33, 8'h11});

    // R7 bad second byte
    fstart(); xfer(8'hFE, g); xfer(8'h00, g); fend();
    chk("R7 no reset", {24'h0, p2_data}, 32'h3C);
    // R7 real reset
    fstart(); xfer(8'hFE, g); xfer(8'hFF, g); fend();
    chk("R7 reset regs", {p0_pullup, p1_dir, p2_data, p2_pullup}, 32'h0);
    wr(8'h0F, 8'h77);
    chk("R7 relocked", {24'h0, p2_data}, 32'h0);
    chk("R12 sdo idle", {31'h0, sdo}, 32'h0);

    #(20*CLK_PERIOD);
    if (exp_q.size() != 0) chk("scoreboard drain", exp_q.size(), 0);
    finish_run();
  end
endmodule